// File: doc/BRIEF.md
# Masked Weekly Alarm Comparator

This block watches the current time of day, given as a BCD minute, a BCD hour and a one-hot weekday, and compares it with three alarm settings: a minute alarm, an hour alarm and a weekday alarm. Each setting is an 8-bit register. Its top bit is a don't-care bit that makes that field count as matching whatever its data bits hold. The weekday setting is not a single value. It is a seven-bit selection, so any set of days can be armed at once.

The comparison is made only on the cycle in which the minute-tick strobe is high. A full match on that cycle sets a sticky alarm flag, which stays set until the host pulses a clear strobe. An active-low interrupt output copies the flag while the interrupt enable is high, and stays high when the enable is low. The timekeeping counters and the host register access sit outside this block.

Top module: `wkalarm_match`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flag goes to 0. After reset, `alarm_flag` is 0 and `irq_n` is 1.
- R2: When `alm_min[7]` is 0, the minute field matches only when `alm_min[6:0]` equals `cur_min[6:0]`. Both values are BCD, with tens in bits 6:4 and units in bits 3:0.
- R3: When `alm_hour[7]` is 0, the hour field matches only when `alm_hour[5:0]` equals `cur_hour[5:0]`. Both values are BCD, with tens in bits 5:4 and units in bits 3:0. Bit 6 of `alm_hour` has no effect on the match.
- R4: When `alm_day[7]` is 0, the weekday field matches when some bit i has both `alm_day[i]` and `cur_day[i]` set, for i from 0 to 6. Bit i stands for weekday i, so several days may be armed at once.
- R5: A field whose bit 7 is 1 counts as matching, whatever its data bits hold.
- R6: The fields are evaluated only in a cycle with `min_tick` high. If all three fields match in that cycle, `alarm_flag` is 1 from the next rising edge on. A match without `min_tick` sets nothing.
- R7: The flag holds its value until a cycle with `flag_clr` high, which clears it at the next edge. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq_n` is low exactly when `alarm_flag` is 1 and `irq_en` is 1. This is combinational, so a change on `irq_en` shows on `irq_n` in the same cycle.
- R9: With all three don't-care bits set, every `min_tick` sets the flag.
- R10: With the minute and hour fields both masked and the weekday field active, every `min_tick` on an armed day sets the flag. The block does not reject this configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| min_tick | input | 1 | One-cycle strobe marking a minute update |
| cur_min | input | 8 | Current minute, BCD in bits 6:0 |
| cur_hour | input | 8 | Current hour, BCD in bits 5:0 |
| cur_day | input | 7 | Current weekday, one-hot |
| alm_min | input | 8 | Minute alarm: bit 7 don't-care, bits 6:0 BCD |
| alm_hour | input | 8 | Hour alarm: bit 7 don't-care, bits 5:0 BCD |
| alm_day | input | 8 | Weekday alarm: bit 7 don't-care, bits 6:0 day select |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| irq_en | input | 1 | Interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench sets a clear and a match in the same cycle; a design that gave the clear priority would lose that alarm. It holds a full match with `min_tick` low, which catches a design that compares on every cycle and sets the flag early. It fills masked fields and hour bit 6 with junk data, which catches a design that still compares masked data or reads bit 6. It arms two weekdays that are far apart and tests the neighbouring days, which exposes a design that compares the weekday for equality or reads the wrong bit.

// File: rtl/wkalarm_pkg.sv
package wkalarm_pkg;

    localparam int REG_W     = 8;
    localparam int MIN_W     = 7;
    localparam int HOUR_W    = 6;
    localparam int DAYS      = 7;
    localparam int DC_BIT    = REG_W - 1;

    typedef struct packed {
        logic             dont_care;
        logic [REG_W-2:0] data;
    } alarm_reg_t;

    typedef struct packed {
        logic min_ok;
        logic hour_ok;
        logic day_ok;
    } field_hits_t;

    function automatic logic all_hit(input field_hits_t h);
        return h.min_ok & h.hour_ok & h.day_ok;
    endfunction

endpackage

// File: rtl/wkalarm_field_cmp.sv
module wkalarm_field_cmp #(
    parameter int W = 7
) (
    input  logic         dont_care,
    input  logic [W-1:0] alarm_val,
    input  logic [W-1:0] now_val,
    output logic         hit
);
    logic [W-1:0] bit_eq;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign bit_eq[i] = ~(alarm_val[i] ^ now_val[i]);
        end
    endgenerate

    // R2 R3 R5
    assign hit = dont_care | (&bit_eq);
endmodule

// File: rtl/wkalarm_day_sel.sv
module wkalarm_day_sel #(
    parameter int N = 7
) (
    input  logic         dont_care,
    input  logic [N-1:0] armed,
    input  logic [N-1:0] today,
    output logic         hit
);
    logic [N-1:0] sel;

    generate
        for (genvar d = 0; d < N; d++) begin : g_day
            assign sel[d] = armed[d] & today[d];
        end
    endgenerate

    // R4 R5
    assign hit = dont_care | (|sel);
endmodule

// File: rtl/wkalarm_flag.sv
module wkalarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    logic set_now;
    assign set_now = tick & hit;

    // R1 R6 R7
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_now) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    // R6
    flag_sets_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && hit) |=> flag);

    // R6
    no_set_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(tick && hit)) |=> !flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R7
    clear_works_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !tick) |=> !flag);
endmodule

// File: rtl/wkalarm_match.sv
module wkalarm_match
    import wkalarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             min_tick,
    input  logic [REG_W-1:0] cur_min,
    input  logic [REG_W-1:0] cur_hour,
    input  logic [DAYS-1:0]  cur_day,
    input  logic [REG_W-1:0] alm_min,
    input  logic [REG_W-1:0] alm_hour,
    input  logic [REG_W-1:0] alm_day,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             alarm_flag,
    output logic             irq_n
);
    alarm_reg_t  a_min, a_hour, a_day;
    field_hits_t hits;
    logic        unused_bits;

    assign a_min  = alarm_reg_t'(alm_min);
    assign a_hour = alarm_reg_t'(alm_hour);
    assign a_day  = alarm_reg_t'(alm_day);

    // R3: hour bit 6 and unused high bits of the current time take no part
    assign unused_bits = ^{cur_min[REG_W-1], cur_hour[REG_W-1:HOUR_W], a_hour.data[REG_W-2:HOUR_W]};

    wkalarm_field_cmp #(.W(MIN_W)) u_min (
        .dont_care (a_min.dont_care),
        .alarm_val (a_min.data[MIN_W-1:0]),
        .now_val   (cur_min[MIN_W-1:0]),
        .hit       (hits.min_ok)
    );

    wkalarm_field_cmp #(.W(HOUR_W)) u_hour (
        .dont_care (a_hour.dont_care),
        .alarm_val (a_hour.data[HOUR_W-1:0]),
        .now_val   (cur_hour[HOUR_W-1:0]),
        .hit       (hits.hour_ok)
    );

    wkalarm_day_sel #(.N(DAYS)) u_day (
        .dont_care (a_day.dont_care),
        .armed     (a_day.data[DAYS-1:0]),
        .today     (cur_day),
        .hit       (hits.day_ok)
    );

    wkalarm_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .tick (min_tick),
        .hit  (all_hit(hits)),
        .clr  (flag_clr),
        .flag (alarm_flag)
    );

    // R8
    assign irq_n = ~(alarm_flag & irq_en);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> irq_n);

    // R9
    all_masked_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (min_tick && alm_min[DC_BIT] && alm_hour[DC_BIT] && alm_day[DC_BIT]) |=> alarm_flag);
endmodule

// File: tb/sim_wkalarm_match.sv
module sim_wkalarm_match;
    logic       clk = 1'b0;
    logic       rst, min_tick, flag_clr, irq_en;
    logic [7:0] cur_min, cur_hour, alm_min, alm_hour, alm_day;
    logic [6:0] cur_day;
    logic       alarm_flag, irq_n;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    bit  mflag = 0;

    always #4 clk = ~clk;

    wkalarm_match u0 (
        .clk(clk), .rst(rst), .min_tick(min_tick),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
        .flag_clr(flag_clr), .irq_en(irq_en),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic int bcd_val(input int tens, input int units);
        return tens * 10 + units;
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic bit ref_hit();
        bit m_ok, h_ok, d_ok;
        m_ok = alm_min[7] ||
               (bcd_val(int'(alm_min[6:4]), int'(alm_min[3:0])) ==
                bcd_val(int'(cur_min[6:4]), int'(cur_min[3:0])));
        h_ok = alm_hour[7] ||
               (bcd_val(int'(alm_hour[5:4]), int'(alm_hour[3:0])) ==
                bcd_val(int'(cur_hour[5:4]), int'(cur_hour[3:0])));
        d_ok = alm_day[7];
        for (int i = 0; i < 7; i++)
            if (alm_day[i] && cur_day[i]) d_ok = 1;
        return m_ok && h_ok && d_ok;
    endfunction

    task automatic cycle(input string tag);
        @(posedge clk);
        if (rst)                        mflag = 0;
        else if (min_tick && ref_hit()) mflag = 1;
        else if (flag_clr)              mflag = 0;
        @(negedge clk);
        n_cmp++;
        if (alarm_flag !== mflag) begin
            n_bad++;
            $display("FAIL %s alarm_flag actual=%b expected=%b", tag, alarm_flag, mflag);
        end
        n_cmp++;
        if (irq_n !== !(mflag && irq_en)) begin
            n_bad++;
            $display("FAIL %s irq_n actual=%b expected=%b", tag, irq_n, !(mflag && irq_en));
        end
    endtask

    task automatic tick_once(input string tag);
        min_tick = 1; cycle(tag);
        min_tick = 0; cycle(tag);
    endtask

    task automatic clear_flag(input string tag);
        flag_clr = 1; cycle(tag);
        flag_clr = 0; cycle(tag);
    endtask

    task automatic set_time(input int m, input int h, input int d);
        cur_min = to_bcd(m); cur_hour = to_bcd(h); cur_day = 7'(1 << d);
    endtask

    initial begin
        rst = 1; min_tick = 0; flag_clr = 0; irq_en = 1;
        set_time(0, 0, 0);
        alm_min = 8'h80; alm_hour = 8'h80; alm_day = 8'h80;
        cycle("R1"); cycle("R1");
        rst = 0; cycle("R1");

        // R2: minute alarm 30, others masked
        alm_min = 8'h30; alm_hour = 8'hFF; alm_day = 8'hFF;
        set_time(29, 5, 2); tick_once("R2");
        set_time(31, 5, 2); tick_once("R2");
        set_time(30, 5, 2); tick_once("R2");
        clear_flag("R7");

        // R6: match without tick sets nothing
        cycle("R6"); cycle("R6");

        // R7: set and clear in the same cycle, set wins
        min_tick = 1; flag_clr = 1; cycle("R7");
        min_tick = 0; flag_clr = 0; cycle("R7"); cycle("R7");
        clear_flag("R7");

        // R8: enable gates irq_n
        tick_once("R8");
        irq_en = 0; cycle("R8");
        irq_en = 1; cycle("R8");
        clear_flag("R8");

        // R3: hour 17 with bit 6 junk, minute 05
        alm_min = 8'h05; alm_hour = 8'h57; alm_day = 8'h80;
        set_time(5, 7, 0);  tick_once("R3");
        set_time(5, 16, 0); tick_once("R3");
        set_time(5, 17, 0); tick_once("R3");
        clear_flag("R3");

        // R4: days 1 and 6 armed, hour masked, minute 00
        alm_min = 8'h00; alm_hour = 8'h80; alm_day = 8'b0100_0010;
        for (int d = 0; d < 7; d++) begin
            set_time(0, 9, d); tick_once("R4");
            clear_flag("R4");
        end

        // R5: masked fields with junk data
        alm_min = 8'hFF; alm_hour = 8'hC3; alm_day = 8'h80;
        set_time(47, 22, 4); tick_once("R5");
        clear_flag("R5");

        // R9: all masked fires on any tick
        alm_min = 8'h80; alm_hour = 8'h80; alm_day = 8'h80;
        set_time(13, 3, 6); tick_once("R9");
        clear_flag("R9");
        tick_once("R9");
        clear_flag("R9");

        // R10: weekday alone
        alm_min = 8'h80; alm_hour = 8'h80; alm_day = 8'b0000_1000;
        set_time(1, 1, 2); tick_once("R10");
        set_time(1, 1, 3); tick_once("R10");
        clear_flag("R10");

        // mixed random stimulus against the model
        for (int k = 0; k < 2000; k++) begin
            set_time($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 6));
            alm_min  = {1'($urandom_range(0, 1)), 7'(to_bcd($urandom_range(0, 3)))};
            alm_hour = {2'($urandom_range(0, 3)), 6'(to_bcd($urandom_range(0, 2)))};
            alm_day  = 8'($urandom_range(0, 255));
            min_tick = ($urandom_range(0, 2) == 0);
            flag_clr = ($urandom_range(0, 3) == 0);
            irq_en   = ($urandom_range(0, 1) == 1);
            cycle("R6");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule